// File: doc/BRIEF.md
# Endian-Configurable Byte Lane Steering

This block sits between a 32-bit host data bus and an internal datapath that always works little endian. For every host register access it produces the internal register offset, the internal byte enables and the realigned write data, so that a register sits on the same physical byte lane whatever byte order the host uses. Full-dword accesses are word-addressed by their least significant byte and go through untouched. Byte and halfword accesses in big endian mode have their offset translated and their lanes mirrored. Accesses that originate inside the core bypass the translation.

The host places a sub-dword byte on the lane its address selects. Internally a register at offset `o` uses lane `o[1:0]`. For a big endian host the block therefore XORs the low offset bits with 3 for bytes and with 2 for halfwords, and it mirrors the lanes (host lane k goes to internal lane 3-k). A second path steers streamed data bytes. Successive bytes take consecutive addresses starting at 0, and each byte lands on the lane its address selects in the current byte order. The byte-order input is sampled only while both paths are idle.

Top module: `endian_lane_steer`

## Requirements
- R1: After reset, `outValid` and `strmOutValid` are 0 and `laneEn` is 0.
- R2: In little endian mode, a byte or halfword access produces `regOffset` equal to `byteAddr`, `laneEn` equal to `byteEn` and `laneData` equal to `wrData`.
- R3: In big endian mode, a byte access (`accSize` = 0) produces `regOffset` equal to `byteAddr` with its low two bits XOR 3. `laneEn` and `laneData` are lane-mirrored (host lane k goes to internal lane 3-k).
- R4: In big endian mode, a halfword access (`accSize` = 1) produces `regOffset` equal to `byteAddr` with its low two bits XOR 2, and its enables and data are lane-mirrored.
- R5: A dword access (`accSize` = 2) passes offset, enables and data through unchanged in either mode.
- R6: With `internalSrc` = 1, an access is treated as little endian whatever the mode.
- R7: `outValid` is 1 exactly in the cycle after a cycle with `reqValid` = 1, and the other outputs for that access are valid in that same cycle.
- R8: `bigEndianIn` is sampled only in cycles where `reqValid` and `strmValid` are both 0. A change while either is high takes effect only after an idle cycle.
- R9: A streamed byte with `strmStart` = 1 gets address 0. Each later streamed byte gets the previous address plus 1, even across idle gaps. One cycle later the address appears on `strmAddr` together with `strmOutValid` = 1.
- R10: A streamed byte at address a goes on lane a[1:0] in little endian mode and on lane 3-a[1:0] in big endian mode. `strmLaneEn` is one-hot on that lane, and the other bytes of `strmBus` are 0.
- R11: Size code 3 is handled exactly like a dword access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Register access present this cycle |
| internalSrc | input | 1 | Access originates inside the core; no translation |
| accSize | input | 2 | 0 byte, 1 halfword, 2 or 3 dword |
| byteAddr | input | AW (8) | Host byte address of the access |
| wrData | input | 32 | Host write data, host lane order |
| byteEn | input | 4 | Host byte enables, host lane order |
| bigEndianIn | input | 1 | Byte order: 1 big endian, 0 little endian |
| strmValid | input | 1 | Streamed data byte present |
| strmStart | input | 1 | Streamed byte starts a new transfer at address 0 |
| strmByte | input | 8 | Streamed data byte |
| outValid | output | 1 | Translated access valid |
| regOffset | output | AW (8) | Internal register offset |
| laneEn | output | 4 | Internal byte enables |
| laneData | output | 32 | Internal realigned data |
| strmOutValid | output | 1 | Steered stream byte valid |
| strmAddr | output | AW (8) | Address assigned to the stream byte |
| strmLaneEn | output | 4 | One-hot lane of the stream byte |
| strmBus | output | 32 | Stream byte placed on its lane |

## Verification
The embedded properties check on every cycle the one-cycle valid latency, the untouched pass-through of dword and internally sourced accesses, and the agreement between a single-byte access's enabled lane and the low bits of its translated offset. They also check that the sampled mode holds while either path is busy, that stream addresses count up by one, and that the stream lane enable is one-hot. Only the bench scenarios can show the exact big endian offsets and the mirrored data values. The same holds for the delayed effect of a mode change made during back-to-back traffic and for the lane a stream byte takes in each byte order.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic swapLanes;
    logic xorByte;
    logic xorHalf;
    logic strmCapture;
    logic strmRestart;
    logic strmBig;
  } steerStrb_t;

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       internalSrc,
  input  logic [1:0] accSize,
  input  logic       bigEndianIn,
  input  logic       strmValid,
  input  logic       strmStart,
  output steerStrb_t strb
);

  logic      modeReg;
  logic      effBig;
  logic      subWord;
  accSize_e  sz;

  assign sz = accSize_e'(accSize);

  // byte order only follows the input while both paths are idle
  always_ff @(posedge clk) begin
    if (!rst_n)
      modeReg <= 1'b0;
    else if (!reqValid && !strmValid)
      modeReg <= bigEndianIn;
  end

  assign effBig  = modeReg && !internalSrc;
  assign subWord = (sz == SZ_BYTE) || (sz == SZ_HALF);

  always_comb begin
    strb             = '0;
    strb.capture     = reqValid;
    strb.swapLanes   = reqValid && effBig && subWord;
    strb.xorByte     = reqValid && effBig && (sz == SZ_BYTE);
    strb.xorHalf     = reqValid && effBig && (sz == SZ_HALF);
    strb.strmCapture = strmValid;
    strb.strmRestart = strmValid && strmStart;
    strb.strmBig     = modeReg;
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid || strmValid) |=> $stable(modeReg));

endmodule

// File: rtl/steer_dp.sv
module steer_dp
  import steer_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  steerStrb_t         strb,
  input  logic [AW-1:0]      byteAddr,
  input  logic [8*LANES-1:0] wrData,
  input  logic [LANES-1:0]   byteEn,
  input  logic [7:0]         strmByte,
  output logic               outValid,
  output logic [AW-1:0]      regOffset,
  output logic [LANES-1:0]   laneEn,
  output logic [8*LANES-1:0] laneData,
  output logic               strmOutValid,
  output logic [AW-1:0]      strmAddr,
  output logic [LANES-1:0]   strmLaneEn,
  output logic [8*LANES-1:0] strmBus
);

  localparam int DW = 8 * LANES;
  localparam int LB = $clog2(LANES);

  logic [AW-1:0]    offMask;
  logic [DW-1:0]    revData;
  logic [LANES-1:0] revEn;
  logic [AW-1:0]    strmCnt;
  logic [AW-1:0]    curAddr;
  logic [LB-1:0]    laneIdx;
  logic [LB-1:0]    physIdx;

  // lane mirror: host lane g feeds internal lane LANES-1-g
  for (genvar g = 0; g < LANES; g++) begin : g_mirror
    assign revData[8*g +: 8] = wrData[8*(LANES-1-g) +: 8];
    assign revEn[g]          = byteEn[LANES-1-g];
  end

  always_comb begin
    offMask = '0;
    if (strb.xorByte)      offMask = AW'(LANES - 1);
    else if (strb.xorHalf) offMask = AW'(LANES - 2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      regOffset <= '0;
      laneEn    <= '0;
      laneData  <= '0;
    end else begin
      outValid <= strb.capture;
      if (strb.capture) begin
        regOffset <= byteAddr ^ offMask;
        laneEn    <= strb.swapLanes ? revEn : byteEn;
        laneData  <= strb.swapLanes ? revData : wrData;
      end
    end
  end

  // streaming path: addresses count up, lane follows byte order
  assign curAddr = strb.strmRestart ? '0 : strmCnt;
  assign laneIdx = curAddr[LB-1:0];
  assign physIdx = strb.strmBig ? (LB'(LANES - 1) - laneIdx) : laneIdx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strmCnt      <= '0;
      strmOutValid <= 1'b0;
      strmAddr     <= '0;
      strmLaneEn   <= '0;
      strmBus      <= '0;
    end else begin
      strmOutValid <= strb.strmCapture;
      if (strb.strmCapture) begin
        strmCnt    <= curAddr + AW'(1);
        strmAddr   <= curAddr;
        strmLaneEn <= LANES'(1) << physIdx;
        strmBus    <= DW'(strmByte) << {physIdx, 3'b000};
      end
    end
  end

  // R10
  strm_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strmOutValid |-> ($countones(strmLaneEn) == 1));

  // R9
  strm_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.strmCapture && !strb.strmRestart && strmOutValid)
      |=> (strmAddr == $past(strmAddr) + AW'(1)));

endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import steer_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic               internalSrc,
  input  logic [1:0]         accSize,
  input  logic [AW-1:0]      byteAddr,
  input  logic [8*LANES-1:0] wrData,
  input  logic [LANES-1:0]   byteEn,
  input  logic               bigEndianIn,
  input  logic               strmValid,
  input  logic               strmStart,
  input  logic [7:0]         strmByte,
  output logic               outValid,
  output logic [AW-1:0]      regOffset,
  output logic [LANES-1:0]   laneEn,
  output logic [8*LANES-1:0] laneData,
  output logic               strmOutValid,
  output logic [AW-1:0]      strmAddr,
  output logic [LANES-1:0]   strmLaneEn,
  output logic [8*LANES-1:0] strmBus
);

  localparam int LB = $clog2(LANES);

  steerStrb_t strb;

  steer_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .internalSrc (internalSrc),
    .accSize     (accSize),
    .bigEndianIn (bigEndianIn),
    .strmValid   (strmValid),
    .strmStart   (strmStart),
    .strb        (strb)
  );

  steer_dp #(.AW(AW), .LANES(LANES)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .byteAddr     (byteAddr),
    .wrData       (wrData),
    .byteEn       (byteEn),
    .strmByte     (strmByte),
    .outValid     (outValid),
    .regOffset    (regOffset),
    .laneEn       (laneEn),
    .laneData     (laneData),
    .strmOutValid (strmOutValid),
    .strmAddr     (strmAddr),
    .strmLaneEn   (strmLaneEn),
    .strmBus      (strmBus)
  );

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !outValid);

  // R5, R11
  word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && accSize[1])
      |=> (regOffset == $past(byteAddr) && laneEn == $past(byteEn)
           && laneData == $past(wrData)));

  // R6
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && internalSrc)
      |=> (regOffset == $past(byteAddr) && laneEn == $past(byteEn)));

  // R3
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && accSize == 2'd0 && byteEn == (LANES'(1) << byteAddr[LB-1:0]))
      |=> (laneEn == (LANES'(1) << regOffset[LB-1:0])));

endmodule

// File: tb/endian_lane_steer_tb.sv
`timescale 1ns/1ps
module endian_lane_steer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        internalSrc = 1'b0;
  logic [1:0]  accSize = 2'd0;
  logic [7:0]  byteAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  byteEn = '0;
  logic        bigEndianIn = 1'b0;
  logic        strmValid = 1'b0;
  logic        strmStart = 1'b0;
  logic [7:0]  strmByte = '0;
  logic        outValid;
  logic [7:0]  regOffset;
  logic [3:0]  laneEn;
  logic [31:0] laneData;
  logic        strmOutValid;
  logic [7:0]  strmAddr;
  logic [3:0]  strmLaneEn;
  logic [31:0] strmBus;

  always #4 clk = ~clk;  // 125 MHz

  endian_lane_steer u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .internalSrc(internalSrc),
    .accSize(accSize), .byteAddr(byteAddr), .wrData(wrData), .byteEn(byteEn),
    .bigEndianIn(bigEndianIn), .strmValid(strmValid), .strmStart(strmStart),
    .strmByte(strmByte), .outValid(outValid), .regOffset(regOffset),
    .laneEn(laneEn), .laneData(laneData), .strmOutValid(strmOutValid),
    .strmAddr(strmAddr), .strmLaneEn(strmLaneEn), .strmBus(strmBus)
  );

  typedef struct {
    logic [7:0]  off;
    logic [3:0]  en;
    logic [31:0] data;
    string       tag;
  } accItem_t;

  typedef struct {
    logic [7:0]  addr;
    logic [3:0]  en;
    logic [31:0] bus;
    string       tag;
  } strmItem_t;

  accItem_t  accQ[$];
  strmItem_t strmQ[$];
  int        totalCnt = 0;
  int        failCnt  = 0;
  bit        done     = 1'b0;

  task automatic check(input bit ok, input string msg);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  // driver: one access per call, held until the next negedge
  task automatic access(input logic modeDrv, input logic isInt, input logic [1:0] sz,
                        input logic [7:0] a, input logic [3:0] be, input logic [31:0] d,
                        input logic expBig, input string tag);
    accItem_t it;
    logic eff;
    eff = expBig && !isInt && (sz < 2'd2);
    it.off = eff ? (a ^ ((sz == 2'd0) ? 8'd3 : 8'd2)) : a;
    for (int k = 0; k < 4; k++) begin
      it.en[k]         = eff ? be[3-k] : be[k];
      it.data[8*k +: 8] = eff ? d[8*(3-k) +: 8] : d[8*k +: 8];
    end
    it.tag = tag;
    accQ.push_back(it);
    reqValid = 1'b1; internalSrc = isInt; accSize = sz;
    byteAddr = a; byteEn = be; wrData = d; bigEndianIn = modeDrv;
    @(negedge clk);
  endtask

  task automatic strm(input logic start, input logic [7:0] b, input logic modeDrv,
                      input logic [7:0] expAddr, input logic expBig, input string tag);
    strmItem_t it;
    int lane;
    lane = expBig ? 3 - int'(expAddr[1:0]) : int'(expAddr[1:0]);
    it.addr = expAddr;
    it.en   = 4'b0001 << lane;
    it.bus  = 32'(b) << (8 * lane);
    it.tag  = tag;
    strmQ.push_back(it);
    strmValid = 1'b1; strmStart = start; strmByte = b; bigEndianIn = modeDrv;
    @(negedge clk);
  endtask

  task automatic idle(input logic modeDrv);
    reqValid = 1'b0; strmValid = 1'b0; strmStart = 1'b0; internalSrc = 1'b0;
    bigEndianIn = modeDrv;
    @(negedge clk);
  endtask

  // monitor: compare produced results against the expectation queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (outValid) begin
        if (accQ.size() == 0)
          check(1'b0, "R7 outValid with no access pending");
        else begin
          accItem_t e;
          e = accQ.pop_front();
          check(regOffset == e.off && laneEn == e.en && laneData == e.data,
                $sformatf("%s off/en/data got %h/%h/%h exp %h/%h/%h", e.tag,
                          regOffset, laneEn, laneData, e.off, e.en, e.data));
        end
      end
      if (strmOutValid) begin
        if (strmQ.size() == 0)
          check(1'b0, "R9 strmOutValid with no byte pending");
        else begin
          strmItem_t s;
          s = strmQ.pop_front();
          check(strmAddr == s.addr && strmLaneEn == s.en && strmBus == s.bus,
                $sformatf("%s addr/en/bus got %h/%h/%h exp %h/%h/%h", s.tag,
                          strmAddr, strmLaneEn, strmBus, s.addr, s.en, s.bus));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failCnt++; totalCnt++;
      $display("FAIL watchdog expired got running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 0 && strmOutValid == 0 && laneEn == 0,
          $sformatf("R1 reset state got %b/%b/%h exp 0/0/0", outValid, strmOutValid, laneEn));
    idle(0); idle(0);

    // R2 little endian sub-dword
    access(0, 0, 2'd0, 8'h11, 4'b0010, 32'h0000AB00, 0, "R2 LE byte");
    access(0, 0, 2'd1, 8'h12, 4'b1100, 32'hBEEF0000, 0, "R2 LE half");
    access(0, 0, 2'd2, 8'h20, 4'b1111, 32'hCAFEF00D, 0, "R5 LE dword");
    idle(1);

    // big endian
    access(1, 0, 2'd0, 8'h10, 4'b0001, 32'h000000CD, 1, "R3 BE byte lane0");
    access(1, 0, 2'd0, 8'h13, 4'b1000, 32'hEF000000, 1, "R3 BE byte lane3");
    access(1, 0, 2'd0, 8'h21, 4'b0010, 32'h00005A00, 1, "R3 BE byte lane1");
    access(1, 0, 2'd1, 8'h10, 4'b0011, 32'h0000BEEF, 1, "R4 BE half low");
    access(1, 0, 2'd1, 8'h12, 4'b1100, 32'h12340000, 1, "R4 BE half high");
    access(1, 0, 2'd2, 8'h24, 4'b1111, 32'h12345678, 1, "R5 BE dword");
    access(1, 0, 2'd3, 8'h28, 4'b1111, 32'h9ABCDEF0, 1, "R11 BE size3");
    access(1, 1, 2'd0, 8'h10, 4'b0001, 32'h00000077, 1, "R6 internal byte");
    access(1, 1, 2'd1, 8'h12, 4'b1100, 32'h55660000, 1, "R6 internal half");

    // R8 mode change while busy has no effect until idle
    access(0, 0, 2'd0, 8'h10, 4'b0001, 32'h00000011, 1, "R8 busy keeps BE");
    access(0, 0, 2'd0, 8'h32, 4'b0100, 32'h00220000, 1, "R8 busy keeps BE 2");
    idle(0);
    access(0, 0, 2'd0, 8'h10, 4'b0001, 32'h00000033, 0, "R8 after idle LE");
    idle(0);
    check(outValid == 0, $sformatf("R7 no output after idle got %b exp 0", outValid));

    // stream, little endian
    strm(1, 8'hA0, 0, 8'd0, 0, "R9 R10 LE start");
    strm(0, 8'hA1, 0, 8'd1, 0, "R10 LE byte1");
    strm(0, 8'hA2, 0, 8'd2, 0, "R10 LE byte2");
    strm(0, 8'hA3, 0, 8'd3, 0, "R10 LE byte3");
    strm(0, 8'hA4, 0, 8'd4, 0, "R9 LE wrap lane");
    idle(1);
    // stream, big endian
    strm(1, 8'hB0, 1, 8'd0, 1, "R10 BE start lane3");
    strm(0, 8'hB1, 1, 8'd1, 1, "R10 BE byte1 lane2");
    idle(1);
    strm(0, 8'hB2, 1, 8'd2, 1, "R9 continue after gap");
    idle(1); idle(1);

    check(accQ.size() == 0 && strmQ.size() == 0,
          $sformatf("R7 R9 pending results got %0d/%0d exp 0/0", accQ.size(), strmQ.size()));
    done = 1'b1;
    summary();
    $finish;
  end

endmodule